// File: doc/BRIEF.md
# Banked Multi-Channel Configuration Register File

This block is the register file of a four-channel device. One shared set holds identity, strap, command, status and general configuration registers. Four identical channel sets each hold seven read-write configuration registers and one read-only channel index. All five sets share one 8-bit address space. A select register at address 0xFF decides where each access lands. With its channel-enable bit clear, accesses reach the shared set. With that bit set, they reach the channel chosen by its low two bits. If a broadcast bit is also set, writes reach all four channels in the same cycle.

A host drives a simple synchronous bus: one address, write data, a write strobe and a read strobe. Read data is registered. Two shared command bits act as one-shot actions. One restores the shared read-write registers to their defaults. The other pulses a reset strobe for the bus-master logic. Both read back as zero once they have fired.

Top module: `chan_bank_regs`

## Requirements
- R1: During and after reset, read data is 0x00, both strobes are low, the select register is 0x00, shared register 0x03 is 0x05, shared register 0x04 is 0x00, and channel register r (0..6) in every channel holds 0x11*(r+1).
- R2: While select bit 2 is 0, reads and writes at any address other than 0xFF use the shared set.
- R3: While select bit 2 is 1, reads and writes use the channel whose index is in select bits 1:0. The other channels are left unchanged.
- R4: While select bits 3 and 2 are both 1, a write to channel address r (0..6) updates register r of all four channels at the same clock edge. Reads return the channel chosen by bits 1:0.
- R5: Broadcast stays on until bit 3 or bit 2 of the select register is written to 0. After that, writes go only to the single channel or to the shared set that the new select value picks.
- R6: A write to 0xFF always loads select bits 3:0, whatever the bank or broadcast setting. Reading 0xFF returns those bits with bits 7:4 as 0.
- R7: Writes to read-only locations are ignored. These are shared 0x00, 0x01 (fixed identity 0x4B) and 0x05, and channel address 0x07, which returns the channel index 0..3.
- R8: Shared register 0x00 returns the 4-bit strap input in bits 7:4 and 0 in bits 3:0. The bus address output equals 0x18 plus the strap value.
- R9: Writing 1 to bit 0 or bit 1 of shared register 0x02 raises the shared-reset strobe or the master-reset strobe, respectively, for exactly one cycle starting the cycle after the write. Register 0x02 reads 0 afterwards. The master strobe changes no register.
- R10: The shared-reset strobe cycle restores the select register and shared registers 0x03 and 0x04 to their defaults. Channel registers are not affected. A host write to a shared register in that same cycle is lost.
- R11: Shared register 0x05 returns the four channel interrupt inputs in bits 7:4 (channel 0 in bit 4) and the configuration-load-done input in bit 0. All other bits read 0.
- R12: Read data is updated one cycle after a read strobe and holds its value while no read strobe is given. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Access address (read and write) |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| strap_addr | input | 4 | Strapped low bits of the bus address |
| chan_irq | input | 4 | Per-channel interrupt state |
| cfg_load_done | input | 1 | Configuration load completed |
| bus_addr | output | 7 | Resulting 7-bit bus address |
| shared_cfg | output | 16 | Shared registers 0x04 (15:8) and 0x03 (7:0) |
| chan_cfg | output | 224 | Channel read-write registers, channel-major, 8 bits each |
| shared_rst_strobe | output | 1 | One-cycle shared-register reset strobe |
| master_rst_strobe | output | 1 | One-cycle bus-master reset strobe |

## Verification
Two events can fall in the same cycle: the shared-reset strobe taking effect and a host write to the select register. The bench provokes this by writing the shared-reset command and, in the very next cycle, writing 0x0C to 0xFF. It then reads 0xFF back and expects 0x00, because the reset has priority. A second overlap is also covered: a broadcast write landing while the read path points at one channel. This is judged by reading other channel indices and the channel output bus afterwards.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    localparam int NUM_CH   = 4;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int CH_REGS  = 8;
    localparam int CH_RW    = CH_REGS - 1;
    localparam int CH_SEL_W = $clog2(NUM_CH);
    localparam int STRAP_W  = 4;

    localparam logic [ADDR_W-1:0] A_STRAP = 8'h00;
    localparam logic [ADDR_W-1:0] A_IDENT = 8'h01;
    localparam logic [ADDR_W-1:0] A_CMD   = 8'h02;
    localparam logic [ADDR_W-1:0] A_CFG0  = 8'h03;
    localparam logic [ADDR_W-1:0] A_CFG1  = 8'h04;
    localparam logic [ADDR_W-1:0] A_STAT  = 8'h05;
    localparam logic [ADDR_W-1:0] A_SEL   = 8'hFF;
    localparam logic [ADDR_W-1:0] A_CHIDX = ADDR_W'(CH_REGS - 1);

    localparam logic [2:0]        VERSION      = 3'd2;
    localparam logic [4:0]        DEVICE_CODE  = 5'h0B;
    localparam logic [DATA_W-1:0] IDENT_BYTE   = {VERSION, DEVICE_CODE};
    localparam logic [DATA_W-1:0] CFG0_DEFAULT = 8'h05;
    localparam logic [DATA_W-1:0] CFG1_DEFAULT = 8'h00;
    localparam logic [6:0]        BUS_BASE     = 7'h18;

    // Select register layout; the positions are what the decoder relies on.
    typedef struct packed {
        logic                bcast;
        logic                chan_en;
        logic [CH_SEL_W-1:0] chan;
    } bank_sel_t;

    localparam int SEL_W = $bits(bank_sel_t);

    typedef enum logic [1:0] {
        RD_SHARED = 2'd0,
        RD_SELECT = 2'd1,
        RD_CHAN   = 2'd2
    } rd_src_e;

    function automatic logic [DATA_W-1:0] chan_default(input int idx);
        return DATA_W'(8'h11 * (idx + 1));
    endfunction

endpackage

// File: rtl/cfgbank_decode.sv
module cfgbank_decode
    import cfgbank_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  bank_sel_t           sel,
    output logic                wr_sel,
    output logic                wr_shared,
    output logic [NUM_CH-1:0]   wr_chan,
    output rd_src_e             rd_src,
    output logic [CH_SEL_W-1:0] rd_chan
);

    logic              is_sel;
    logic [NUM_CH-1:0] chan_onehot;

    assign is_sel = (addr == A_SEL);

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_onehot
            assign chan_onehot[g] = (sel.chan == CH_SEL_W'(g));
        end
    endgenerate

    always_comb begin
        wr_sel    = wr_en && is_sel;
        wr_shared = wr_en && !is_sel && !sel.chan_en;
        wr_chan   = '0;
        if (wr_en && !is_sel && sel.chan_en) begin
            wr_chan = sel.bcast ? '1 : chan_onehot;
        end
    end

    always_comb begin
        if (is_sel) begin
            rd_src = RD_SELECT;
        end else if (sel.chan_en) begin
            rd_src = RD_CHAN;
        end else begin
            rd_src = RD_SHARED;
        end
        rd_chan = sel.chan;
    end

endmodule

// File: rtl/cfgbank_shared.sv
module cfgbank_shared
    import cfgbank_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_sel,
    input  logic               wr_shared,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [STRAP_W-1:0] strap,
    input  logic [NUM_CH-1:0]  irq,
    input  logic               load_done,
    output bank_sel_t          sel,
    output logic [DATA_W-1:0]  rd_val,
    output logic [DATA_W-1:0]  cfg0,
    output logic [DATA_W-1:0]  cfg1,
    output logic               shared_rst_pulse,
    output logic               master_rst_pulse
);

    logic cmd_write;
    assign cmd_write = wr_shared && (addr == A_CMD);

    // One-shot command flops: each lives for exactly one cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            shared_rst_pulse <= 1'b0;
            master_rst_pulse <= 1'b0;
        end else begin
            shared_rst_pulse <= cmd_write && wr_data[0];
            master_rst_pulse <= cmd_write && wr_data[1];
        end
    end

    // Read-write shared state; the shared-reset pulse outranks host writes.
    always_ff @(posedge clk) begin
        if (rst || shared_rst_pulse) begin
            sel  <= '0;
            cfg0 <= CFG0_DEFAULT;
            cfg1 <= CFG1_DEFAULT;
        end else begin
            if (wr_sel) begin
                sel <= bank_sel_t'(wr_data[SEL_W-1:0]);
            end
            if (wr_shared && addr == A_CFG0) begin
                cfg0 <= wr_data;
            end
            if (wr_shared && addr == A_CFG1) begin
                cfg1 <= wr_data;
            end
        end
    end

    always_comb begin
        rd_val = '0;
        case (addr)
            A_STRAP: rd_val[DATA_W-1 -: STRAP_W] = strap;
            A_IDENT: rd_val = IDENT_BYTE;
            A_CMD:   rd_val[1:0] = {master_rst_pulse, shared_rst_pulse};
            A_CFG0:  rd_val = cfg0;
            A_CFG1:  rd_val = cfg1;
            A_STAT: begin
                rd_val[DATA_W-1 -: NUM_CH] = irq;
                rd_val[0]                  = load_done;
            end
            A_SEL:   rd_val[SEL_W-1:0] = sel;
            default: rd_val = '0;
        endcase
    end

endmodule

// File: rtl/cfgbank_chan.sv
module cfgbank_chan
    import cfgbank_pkg::*;
#(
    parameter int CH_IDX = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [DATA_W-1:0]       rd_val,
    output logic [CH_RW*DATA_W-1:0] cfg_flat
);

    logic [CH_RW-1:0][DATA_W-1:0] regs;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < CH_RW; r++) begin
                regs[r] <= chan_default(r);
            end
        end else if (wr_en) begin
            for (int r = 0; r < CH_RW; r++) begin
                if (addr == ADDR_W'(r)) begin
                    regs[r] <= wr_data;
                end
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < CH_RW; g++) begin : g_flat
            assign cfg_flat[g*DATA_W +: DATA_W] = regs[g];
        end
    endgenerate

    always_comb begin
        rd_val = '0;
        for (int r = 0; r < CH_RW; r++) begin
            if (addr == ADDR_W'(r)) begin
                rd_val = regs[r];
            end
        end
        if (addr == A_CHIDX) begin
            rd_val = DATA_W'(CH_IDX);
        end
    end

endmodule

// File: rtl/chan_bank_regs.sv
module chan_bank_regs
    import cfgbank_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic                           wr_en,
    input  logic                           rd_en,
    output logic [DATA_W-1:0]              rd_data,
    input  logic [STRAP_W-1:0]             strap_addr,
    input  logic [NUM_CH-1:0]              chan_irq,
    input  logic                           cfg_load_done,
    output logic [6:0]                     bus_addr,
    output logic [2*DATA_W-1:0]            shared_cfg,
    output logic [NUM_CH*CH_RW*DATA_W-1:0] chan_cfg,
    output logic                           shared_rst_strobe,
    output logic                           master_rst_strobe
);

    bank_sel_t             bank_sel;
    logic                  wr_sel;
    logic                  wr_shared;
    logic [NUM_CH-1:0]     wr_chan;
    rd_src_e               rd_src;
    logic [CH_SEL_W-1:0]   rd_chan;
    logic [DATA_W-1:0]     shared_rd;
    logic [DATA_W-1:0]     cfg0;
    logic [DATA_W-1:0]     cfg1;
    logic [DATA_W-1:0]     chan_rd [NUM_CH];
    logic [DATA_W-1:0]     rd_next;

    cfgbank_decode u_decode (
        .addr      (addr),
        .wr_en     (wr_en),
        .sel       (bank_sel),
        .wr_sel    (wr_sel),
        .wr_shared (wr_shared),
        .wr_chan   (wr_chan),
        .rd_src    (rd_src),
        .rd_chan   (rd_chan)
    );

    cfgbank_shared u_shared (
        .clk              (clk),
        .rst              (rst),
        .wr_sel           (wr_sel),
        .wr_shared        (wr_shared),
        .addr             (addr),
        .wr_data          (wr_data),
        .strap            (strap_addr),
        .irq              (chan_irq),
        .load_done        (cfg_load_done),
        .sel              (bank_sel),
        .rd_val           (shared_rd),
        .cfg0             (cfg0),
        .cfg1             (cfg1),
        .shared_rst_pulse (shared_rst_strobe),
        .master_rst_pulse (master_rst_strobe)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_chan
            cfgbank_chan #(.CH_IDX(g)) u_chan (
                .clk      (clk),
                .rst      (rst),
                .wr_en    (wr_chan[g]),
                .addr     (addr),
                .wr_data  (wr_data),
                .rd_val   (chan_rd[g]),
                .cfg_flat (chan_cfg[g*CH_RW*DATA_W +: CH_RW*DATA_W])
            );
        end
    endgenerate

    always_comb begin
        case (rd_src)
            RD_CHAN: rd_next = chan_rd[rd_chan];
            default: rd_next = shared_rd;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_next;
        end
    end

    assign bus_addr   = BUS_BASE + {3'b000, strap_addr};
    assign shared_cfg = {cfg1, cfg0};

endmodule

// File: rtl/cfgbank_checker.sv
module cfgbank_checker
    import cfgbank_pkg::*;
(
    input logic                           clk,
    input logic                           rst,
    input logic [ADDR_W-1:0]              addr,
    input logic [DATA_W-1:0]              wr_data,
    input logic                           wr_en,
    input logic                           rd_en,
    input logic [DATA_W-1:0]              rd_data,
    input logic [NUM_CH-1:0]              chan_irq,
    input logic                           cfg_load_done,
    input logic [NUM_CH*CH_RW*DATA_W-1:0] chan_cfg,
    input logic                           shared_rst_strobe,
    input logic                           master_rst_strobe,
    input logic [SEL_W-1:0]               sel_bits
);

    assert_sel_write_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_SEL && !shared_rst_strobe) |=> sel_bits == $past(wr_data[SEL_W-1:0]));

    assert_sel_default_R10: assert property (@(posedge clk) disable iff (rst)
        shared_rst_strobe |=> sel_bits == '0);

    assert_shared_strobe_single_R9: assert property (@(posedge clk) disable iff (rst)
        shared_rst_strobe |=> !shared_rst_strobe);

    assert_master_strobe_single_R9: assert property (@(posedge clk) disable iff (rst)
        master_rst_strobe |=> !master_rst_strobe);

    assert_ident_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_IDENT && !sel_bits[SEL_W-2]) |=> rd_data == IDENT_BYTE);

    assert_status_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_STAT && !sel_bits[SEL_W-2])
        |=> rd_data == {$past(chan_irq), 3'b000, $past(cfg_load_done)});

    assert_rd_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_bc
            assert_bcast_all_R4: assert property (@(posedge clk) disable iff (rst)
                (wr_en && addr < ADDR_W'(CH_RW) && sel_bits[SEL_W-1] && sel_bits[SEL_W-2])
                |=> chan_cfg[(c*CH_RW + int'($past(addr[2:0])))*DATA_W +: DATA_W] == $past(wr_data));
        end
    endgenerate

endmodule

bind chan_bank_regs cfgbank_checker u_cfgbank_checker (
    .clk               (clk),
    .rst               (rst),
    .addr              (addr),
    .wr_data           (wr_data),
    .wr_en             (wr_en),
    .rd_en             (rd_en),
    .rd_data           (rd_data),
    .chan_irq          (chan_irq),
    .cfg_load_done     (cfg_load_done),
    .chan_cfg          (chan_cfg),
    .shared_rst_strobe (shared_rst_strobe),
    .master_rst_strobe (master_rst_strobe),
    .sel_bits          (bank_sel)
);

// File: tb/chan_bank_regs_bench.sv
module chan_bank_regs_bench;
    import cfgbank_pkg::*;

    logic                           clk = 1'b0;
    logic                           rst = 1'b1;
    logic [7:0]                     addr = '0;
    logic [7:0]                     wr_data = '0;
    logic                           wr_en = 1'b0;
    logic                           rd_en = 1'b0;
    logic [7:0]                     rd_data;
    logic [3:0]                     strap_addr = 4'h5;
    logic [3:0]                     chan_irq = 4'b0110;
    logic                           cfg_load_done = 1'b1;
    logic [6:0]                     bus_addr;
    logic [15:0]                    shared_cfg;
    logic [NUM_CH*CH_RW*8-1:0]      chan_cfg;
    logic                           shared_rst_strobe;
    logic                           master_rst_strobe;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    chan_bank_regs u_chan_bank_regs (
        .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
        .rd_en(rd_en), .rd_data(rd_data), .strap_addr(strap_addr),
        .chan_irq(chan_irq), .cfg_load_done(cfg_load_done), .bus_addr(bus_addr),
        .shared_cfg(shared_cfg), .chan_cfg(chan_cfg),
        .shared_rst_strobe(shared_rst_strobe), .master_rst_strobe(master_rst_strobe)
    );

    // Entry: {is_read, address, data_or_expected, requirement number}
    localparam int NV = 38;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 8'h00, 8'h50, 4'd8},   // R8 strap field
        {1'b1, 8'h01, 8'h4B, 4'd7},   // R7 identity
        {1'b0, 8'h01, 8'hFF, 4'd7},
        {1'b1, 8'h01, 8'h4B, 4'd7},   // R7 write ignored
        {1'b1, 8'h05, 8'h61, 4'd11},  // R11 status
        {1'b1, 8'h03, 8'h05, 4'd1},   // R1 shared default
        {1'b0, 8'h03, 8'h3C, 4'd2},
        {1'b1, 8'h03, 8'h3C, 4'd2},   // R2 shared write
        {1'b0, 8'hFF, 8'h04, 4'd3},
        {1'b1, 8'h03, 8'h44, 4'd3},   // R3 channel 0 default
        {1'b0, 8'h03, 8'hA1, 4'd3},
        {1'b1, 8'h03, 8'hA1, 4'd3},
        {1'b0, 8'hFF, 8'h06, 4'd3},
        {1'b1, 8'h03, 8'h44, 4'd3},   // R3 channel 2 isolated
        {1'b0, 8'hFF, 8'h00, 4'd2},
        {1'b1, 8'h03, 8'h3C, 4'd2},   // R2 shared kept
        {1'b0, 8'hFF, 8'h0D, 4'd4},
        {1'b0, 8'h02, 8'h5E, 4'd4},
        {1'b1, 8'h02, 8'h5E, 4'd4},   // R4 broadcast read from ch1
        {1'b1, 8'hFF, 8'h0D, 4'd6},   // R6 select readback
        {1'b0, 8'hFF, 8'hF7, 4'd6},
        {1'b1, 8'hFF, 8'h07, 4'd6},   // R6 upper bits zero
        {1'b1, 8'h02, 8'h5E, 4'd4},   // R4 ch3 got broadcast
        {1'b1, 8'h03, 8'h44, 4'd3},
        {1'b0, 8'hFF, 8'h04, 4'd4},
        {1'b1, 8'h02, 8'h5E, 4'd4},   // R4 ch0 got broadcast
        {1'b1, 8'h03, 8'hA1, 4'd3},
        {1'b1, 8'h07, 8'h00, 4'd7},   // R7 channel index
        {1'b0, 8'h07, 8'h99, 4'd7},
        {1'b1, 8'h07, 8'h00, 4'd7},
        {1'b0, 8'hFF, 8'h05, 4'd7},
        {1'b1, 8'h07, 8'h01, 4'd7},
        {1'b1, 8'h09, 8'h00, 4'd12},  // R12 unmapped channel
        {1'b0, 8'hFF, 8'h00, 4'd12},
        {1'b1, 8'h09, 8'h00, 4'd12},  // R12 unmapped shared
        {1'b0, 8'h00, 8'hEE, 4'd7},
        {1'b1, 8'h00, 8'h50, 4'd7},   // R7 strap not writable
        {1'b1, 8'h06, 8'h00, 4'd12}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    function automatic logic [7:0] chreg(input int ch, input int r);
        return chan_cfg[(ch*CH_RW + r)*8 +: 8];
    endfunction

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        check("R1 rd_data in reset", rd_data, 8'h00);
        check("R1 strobes in reset", {6'b0, master_rst_strobe, shared_rst_strobe}, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R1 shared_cfg low", shared_cfg[7:0], 8'h05);
        check("R1 shared_cfg high", shared_cfg[15:8], 8'h00);
        check("R1 ch3 reg6 default", chreg(3, 6), 8'h77);
        check("R1 ch1 reg0 default", chreg(1, 0), 8'h11);
        do_read(8'hFF, v);
        check("R1 select default", v, 8'h00);
        check("R8 bus address", {1'b0, bus_addr}, 8'h1D);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20]) begin
                do_read(VEC[i][19:12], v);
                check($sformatf("R%0d vector %0d", VEC[i][3:0], i), v, VEC[i][11:4]);
            end else begin
                do_write(VEC[i][19:12], VEC[i][11:4]);
            end
        end

        // R5: broadcast persists, ends when bit 2 or bit 3 cleared
        do_write(8'hFF, 8'h0C);
        do_write(8'h04, 8'h22);
        do_write(8'h00, 8'h9A);
        check("R5 broadcast still on ch2", chreg(2, 0), 8'h9A);
        do_write(8'hFF, 8'h08);
        do_write(8'h04, 8'h33);
        check("R5 bit2 clear goes shared", shared_cfg[15:8], 8'h33);
        check("R5 channels kept", chreg(3, 4), 8'h22);
        do_write(8'hFF, 8'h0C);
        do_write(8'hFF, 8'h04);
        do_write(8'h05, 8'h77);
        check("R5 bit3 clear ch0 written", chreg(0, 5), 8'h77);
        check("R5 bit3 clear ch3 untouched", chreg(3, 5), 8'h66);

        // R12: hold without read strobe
        do_read(8'h05, v);
        repeat (3) @(negedge clk);
        check("R12 hold", rd_data, 8'h77);

        // R9 and R10: shared reset command
        do_write(8'hFF, 8'h00);
        do_write(8'h03, 8'h77);
        do_write(8'hFF, 8'h0B);
        do_write(8'h02, 8'h01);
        check("R9 shared strobe high", {7'b0, shared_rst_strobe}, 8'h01);
        check("R9 master strobe low", {7'b0, master_rst_strobe}, 8'h00);
        @(negedge clk);
        check("R9 shared strobe one cycle", {7'b0, shared_rst_strobe}, 8'h00);
        do_read(8'hFF, v);
        check("R10 select restored", v, 8'h00);
        do_read(8'h03, v);
        check("R10 shared cfg restored", v, 8'h05);
        do_read(8'h02, v);
        check("R9 command reads zero", v, 8'h00);
        check("R10 channel untouched", chreg(0, 5), 8'h77);

        // R9: master strobe changes nothing
        do_write(8'h03, 8'h99);
        do_write(8'h02, 8'h02);
        check("R9 master strobe high", {7'b0, master_rst_strobe}, 8'h01);
        check("R9 no shared strobe", {7'b0, shared_rst_strobe}, 8'h00);
        @(negedge clk);
        check("R9 master one cycle", {7'b0, master_rst_strobe}, 8'h00);
        do_read(8'h03, v);
        check("R9 master keeps shared", v, 8'h99);

        // R10: reset pulse collides with select write
        do_write(8'h02, 8'h01);
        addr = 8'hFF; wr_data = 8'h0C; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        do_read(8'hFF, v);
        check("R10 reset beats select write", v, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule